// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the 32-bit general registers and saved status words of a processor that runs in one of seven operating modes. Software addresses sixteen architectural registers, r0 to r15. A five-bit current-mode input chooses which physical copy each of those addresses reaches. The low eight registers and r15 are common to every mode. The fast-interrupt mode owns private copies of r8 to r14. The interrupt, supervisor, abort and undefined modes each own private copies of r13 and r14 only. User and system modes use the base set.

The block has two combinational read ports and one synchronous write port. All three are translated through the same mode-dependent map. A further port reads and writes the saved status word that belongs to the current mode.

Changing the mode copies no data. Every access is steered straight to its physical slot, so a mode switch takes effect in the same cycle as the new mode value. In total the block stores 31 general registers and 5 saved status words.

Top module: `mrf_banked_regfile`

## Requirements
- R1: The mode input codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system, and each code selects its own bank of copies.
- R2: r0 to r7 and r15 reach the same physical register in every mode.
- R3: In fast-interrupt mode (0x11), r8 to r14 reach seven copies that no other mode can see.
- R4: Interrupt, supervisor, abort and undefined modes each have their own private r13 and r14, and they share r8 to r12 with user mode.
- R5: System mode (0x1F) reaches exactly the same physical registers as user mode (0x10).
- R6: Each of the five exception modes has its own saved status word. It is read on psr_rd_data, and a psr_wr_en write becomes visible from the next cycle on.
- R7: In user or system mode, a saved status read returns zero and a saved status write changes no stored word.
- R8: When rst_n is low at a rising clock edge, every general register, every banked copy and every saved status word becomes zero. Writes are ignored during that edge.
- R9: Reads are combinational. A write becomes visible in the cycle after its clock edge. A read of the register being written in the same cycle returns the old value.
- R10: A mode code outside the seven defined codes banks as user mode: it has no saved status word and reaches the user copies.
- R11: The two read ports decode their addresses independently and may read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current operating mode code |
| rd_a_addr | input | 4 | Read port A architectural register |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B architectural register |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable for the general register port |
| wr_addr | input | 4 | Write port architectural register |
| wr_data | input | 32 | Write data |
| psr_wr_en | input | 1 | Write enable for the current mode's saved status word |
| psr_wr_data | input | 32 | Saved status write data |
| psr_rd_data | output | 32 | Saved status word of the current mode |

## Verification
Read data and saved status data depend only on the present mode, addresses and stored state. They are therefore due in the same cycle as the stimulus, and the bench samples them one time unit after it drives inputs at the falling edge. A write, either general or saved status, or a reset edge changes what those outputs show from the following cycle on. The reference model therefore applies each write only after the rising edge, so a read of the register being written still expects the old value. Each comparison is tagged with the banking rule it exercises: shared, fast-interrupt private, exception private, system alias, undefined code, collision or post-reset.

// File: rtl/mrf_pkg.sv
// Package: shared types and storage layout constants for the banked register file.
// Assumes architectural register numbers are 4 bits (r0..r15).
package mrf_pkg;

    localparam int ARCH_REGS    = 16;
    localparam int ARCH_W       = 4;
    localparam int MODE_W       = 5;
    localparam int FIQ_FIRST    = 8;            // first register privately banked for fast interrupt
    localparam int FIQ_COUNT    = 7;            // r8..r14
    localparam int PRIV_FIRST   = 13;           // first register banked for other exception modes
    localparam int PRIV_COUNT   = 2;            // r13, r14
    localparam int PRIV_MODES   = 4;            // irq, svc, abt, und
    localparam int FIQ_BASE     = ARCH_REGS;                    // 16
    localparam int PRIV_BASE    = FIQ_BASE + FIQ_COUNT;         // 23
    localparam int GPR_PHYS     = PRIV_BASE + PRIV_MODES * PRIV_COUNT; // 31
    localparam int PSR_SLOTS    = PRIV_MODES + 1;               // 5
    localparam int PHYS_W       = $clog2(GPR_PHYS);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    // Bank classes; the order from BANK_FIQ onward is the saved-status slot order.
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

endpackage

// File: rtl/mrf_mode_decode.sv
// Module: mrf_mode_decode
// Turns the 5-bit mode code into a bank class. System mode and every
// undefined code fold onto the user bank. Purely combinational.
module mrf_mode_decode
    import mrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o
);

    // Map the mode code onto the bank class it uses.
    always_comb begin
        unique case (mode_i)
            MODE_FIQ: bank_o = BANK_FIQ;
            MODE_IRQ: bank_o = BANK_IRQ;
            MODE_SVC: bank_o = BANK_SVC;
            MODE_ABT: bank_o = BANK_ABT;
            MODE_UND: bank_o = BANK_UND;
            default:  bank_o = BANK_USR;   // user, system and undefined codes
        endcase
    end

endmodule

// File: rtl/mrf_addr_map.sv
// Module: mrf_addr_map
// Translates an architectural register number plus bank class into a
// physical slot index. Slots 0..15 are the base set, 16..22 the
// fast-interrupt r8..r14, then pairs of r13/r14 for irq, svc, abt, und.
module mrf_addr_map
    import mrf_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [ARCH_W-1:0] arch_i,
    output logic [PHYS_W-1:0] phys_o
);

    logic fiq_range;
    logic priv_range;

    // Classify the architectural number against the banked windows.
    always_comb begin
        fiq_range  = (int'(arch_i) >= FIQ_FIRST)  && (int'(arch_i) < FIQ_FIRST + FIQ_COUNT);
        priv_range = (int'(arch_i) >= PRIV_FIRST) && (int'(arch_i) < PRIV_FIRST + PRIV_COUNT);
    end

    // Select base, fast-interrupt or exception-private slot.
    always_comb begin
        phys_o = PHYS_W'(arch_i);
        if (bank_i == BANK_FIQ && fiq_range) begin
            phys_o = PHYS_W'(FIQ_BASE + int'(arch_i) - FIQ_FIRST);
        end else if (bank_i != BANK_USR && bank_i != BANK_FIQ && priv_range) begin
            phys_o = PHYS_W'(PRIV_BASE
                             + (int'(bank_i) - int'(BANK_IRQ)) * PRIV_COUNT
                             + int'(arch_i) - PRIV_FIRST);
        end
    end

endmodule

// File: rtl/mrf_gpr_array.sv
// Module: mrf_gpr_array
// Physical general register storage: NRD combinational read ports, one
// write port, synchronous active-low clear. No write-to-read bypass.
module mrf_gpr_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 31,
    parameter int NRD    = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Clear on reset, otherwise store the write data into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en && int'(wr_idx) < DEPTH) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // One combinational mux per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = (int'(rd_idx[p]) < DEPTH) ? mem[rd_idx[p]] : '0;
        end
    end

    // R9: the written slot holds the written value one edge later.
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) < DEPTH) |=> (mem[$past(wr_idx)] == $past(wr_data)));

    // R9: without a write, storage does not change.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));

    // R8: leaving reset, all storage is zero.
    p_reset_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem == '0));

endmodule

// File: rtl/mrf_spsr_bank.sv
// Module: mrf_spsr_bank
// Saved status words, one per exception bank. In the user bank the read
// returns zero and writes are dropped.
module mrf_spsr_bank
    import mrf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SLOT_W = $clog2(PSR_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [PSR_SLOTS-1:0][DATA_W-1:0] store;
    logic                             has_slot;
    logic [SLOT_W-1:0]                slot;

    // Derive the slot number from the bank class.
    always_comb begin
        has_slot = (bank_i != BANK_USR);
        slot     = has_slot ? SLOT_W'(int'(bank_i) - int'(BANK_FIQ)) : '0;
    end

    // Clear on reset, otherwise write the current bank's slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_en && has_slot) begin
            store[slot] <= wr_data;
        end
    end

    // Present the current bank's word, or zero without a slot.
    always_comb begin
        rd_data = has_slot ? store[slot] : '0;
    end

    // R7: the user bank reads as zero.
    p_usr_psr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_i == BANK_USR) |-> (rd_data == '0));

    // R7: a write in the user bank leaves every word untouched.
    p_usr_psr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_i == BANK_USR) |=> $stable(store));

    // R6: a write in an exception bank reads back next cycle in that bank.
    p_psr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && has_slot) |=> (store[$past(slot)] == $past(wr_data)));

endmodule

// File: rtl/mrf_banked_regfile.sv
// Module: mrf_banked_regfile (top)
// Mode-banked register file: two read ports, one write port and a saved
// status port, all steered by the current mode. Assumes the mode input is
// stable for the whole cycle; no data moves on a mode change.
module mrf_banked_regfile
    import mrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              psr_wr_en,
    input  logic [DATA_W-1:0] psr_wr_data,
    output logic [DATA_W-1:0] psr_rd_data
);

    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 1;   // read ports then the write port

    bank_e                           bank;
    logic [NMAP-1:0][ARCH_W-1:0]     arch_idx;
    logic [NMAP-1:0][PHYS_W-1:0]     phys_idx;
    logic [NRD-1:0][PHYS_W-1:0]      rd_idx;
    logic [NRD-1:0][DATA_W-1:0]      rd_data;

    mrf_mode_decode u_decode (
        .mode_i (mode_i),
        .bank_o (bank)
    );

    // Gather the architectural addresses of all ports.
    always_comb begin
        arch_idx[0] = rd_a_addr;
        arch_idx[1] = rd_b_addr;
        arch_idx[2] = wr_addr;
    end

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        mrf_addr_map u_map (
            .bank_i (bank),
            .arch_i (arch_idx[m]),
            .phys_o (phys_idx[m])
        );
    end

    // Route mapped read indices into the array.
    always_comb begin
        for (int p = 0; p < NRD; p++) begin
            rd_idx[p] = phys_idx[p];
        end
    end

    mrf_gpr_array #(
        .DATA_W (DATA_W),
        .DEPTH  (GPR_PHYS),
        .NRD    (NRD)
    ) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (phys_idx[NRD]),
        .wr_data (wr_data)
    );

    mrf_spsr_bank #(
        .DATA_W (DATA_W)
    ) u_spsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (bank),
        .wr_en   (psr_wr_en),
        .wr_data (psr_wr_data),
        .rd_data (psr_rd_data)
    );

    // Drive the read data ports.
    always_comb begin
        rd_a_data = rd_data[0];
        rd_b_data = rd_data[1];
    end

    // R2: r15 always reaches the shared slot, whatever the mode.
    p_r15_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == 4'd15) |-> (phys_idx[0] == PHYS_W'(15)));

    // R3: fast-interrupt writes to r8..r14 land only in the private window.
    p_fiq_private_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FIQ && wr_addr >= 4'd8 && wr_addr <= 4'd14)
        |-> (phys_idx[NRD] >= PHYS_W'(FIQ_BASE) && phys_idx[NRD] < PHYS_W'(PRIV_BASE)));

    // R5 and R10: system and undefined codes never reach a banked slot.
    p_sys_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BANK_USR) |-> (phys_idx[NRD] < PHYS_W'(ARCH_REGS)));

endmodule

// File: tb/mrf_banked_regfile_tb.sv
// Bench: behavioural reference model (associative arrays keyed by owner),
// compared on every clock against the register file outputs.
module mrf_banked_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'h10;
    logic [3:0]  rd_a_addr = '0;
    logic [3:0]  rd_b_addr = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        psr_wr_en = 1'b0;
    logic [31:0] psr_wr_data = '0;
    logic [31:0] rd_a_data, rd_b_data, psr_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit prev_rst_n = 1'b0;

    logic [31:0] gm [int];
    logic [31:0] pm [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    mrf_banked_regfile dut_i (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i),
        .rd_a_addr (rd_a_addr), .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr), .rd_b_data (rd_b_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .psr_wr_en (psr_wr_en), .psr_wr_data (psr_wr_data),
        .psr_rd_data (psr_rd_data)
    );

    function automatic bit known_mode(logic [4:0] m);
        return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    endfunction

    function automatic bit has_psr(logic [4:0] m);
        return m inside {5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
    endfunction

    // Owner key of an architectural register seen in mode m.
    function automatic int gkey(logic [4:0] m, logic [3:0] r);
        if (r < 8 || r == 15) return int'(r);
        if (m == 5'h11) return 1100 + int'(r);
        if (m inside {5'h12, 5'h13, 5'h17, 5'h1B} && r >= 13) return int'(m) * 100 + int'(r);
        return int'(r);
    endfunction

    function automatic logic [31:0] gread(logic [4:0] m, logic [3:0] r);
        int k = gkey(m, r);
        return gm.exists(k) ? gm[k] : 32'h0;
    endfunction

    function automatic string gtag(logic [4:0] m, logic [3:0] r);
        if (!prev_rst_n) return "R8";
        if (wr_en && gkey(m, wr_addr) == gkey(m, r)) return "R9";
        if (!known_mode(m)) return "R10";
        if (r < 8 || r == 15) return "R2";
        if (m == 5'h11) return "R3";
        if (m == 5'h1F) return "R5";
        return "R4";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s mode=%h actual=%h expected=%h", tag, mode_i, act, exp);
        end
    endtask

    // Compare outputs, then advance one clock and update the model.
    task automatic step();
        logic [31:0] pexp;
        #1;
        check(gtag(mode_i, rd_a_addr), rd_a_data, gread(mode_i, rd_a_addr));
        check({gtag(mode_i, rd_b_addr), ",R11"}, rd_b_data, gread(mode_i, rd_b_addr));
        pexp = (has_psr(mode_i) && pm.exists(int'(mode_i))) ? pm[int'(mode_i)] : 32'h0;
        check(has_psr(mode_i) ? "R1,R6" : "R7", psr_rd_data, pexp);
        @(posedge clk);
        if (!rst_n) begin
            gm.delete();
            pm.delete();
        end else begin
            if (wr_en) gm[gkey(mode_i, wr_addr)] = wr_data;
            if (psr_wr_en && has_psr(mode_i)) pm[int'(mode_i)] = psr_wr_data;
        end
        prev_rst_n = rst_n;
        @(negedge clk);
    endtask

    task automatic drive(logic [4:0] m, logic [3:0] ra, logic [3:0] rb,
                         logic we, logic [3:0] wa, logic [31:0] wd,
                         logic pwe, logic [31:0] pwd);
        mode_i = m; rd_a_addr = ra; rd_b_addr = rb;
        wr_en = we; wr_addr = wa; wr_data = wd;
        psr_wr_en = pwe; psr_wr_data = pwd;
        step();
    endtask

    task automatic sweep_read(logic [4:0] m);
        for (int r = 0; r < 16; r++) drive(m, 4'(r), 4'(15 - r), 1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic fill(logic [4:0] m, int lo, int hi, logic [31:0] base);
        for (int r = lo; r <= hi; r++) drive(m, 4'(r), 4'(r), 1'b1, 4'(r), base + 32'(r), 1'b0, '0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] modes [9] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00, 5'h15};
        @(negedge clk);
        // R8: reset state
        rst_n = 1'b0;
        drive(5'h10, 4'd3, 4'd14, 1'b1, 4'd3, 32'hDEAD, 1'b0, '0);
        drive(5'h11, 4'd9, 4'd15, 1'b0, '0, '0, 1'b1, 32'hBEEF);
        rst_n = 1'b1;
        sweep_read(5'h11);
        // R2, R4, R5: user base set, then views from other modes
        fill(5'h10, 0, 15, 32'h1000_0000);
        sweep_read(5'h1F);
        sweep_read(5'h11);
        // R3: private fast-interrupt copies
        fill(5'h11, 8, 14, 32'h1100_0000);
        sweep_read(5'h11);
        sweep_read(5'h10);
        // R4: private r13/r14 per exception mode
        fill(5'h12, 13, 14, 32'h1200_0000);
        fill(5'h13, 13, 14, 32'h1300_0000);
        fill(5'h17, 13, 14, 32'h1700_0000);
        fill(5'h1B, 13, 14, 32'h1B00_0000);
        foreach (modes[i]) sweep_read(modes[i]);
        // R10: undefined code writes the user copy
        drive(5'h05, 4'd13, 4'd8, 1'b1, 4'd13, 32'h0505_0505, 1'b0, '0);
        sweep_read(5'h10);
        // R6, R7: saved status words
        foreach (modes[i]) drive(modes[i], 4'd0, 4'd1, 1'b0, '0, '0, 1'b1, 32'hA000_0000 + 32'(i));
        foreach (modes[i]) drive(modes[i], 4'd14, 4'd13, 1'b0, '0, '0, 1'b0, '0);
        // R9: same-cycle read of the register being written
        drive(5'h13, 4'd14, 4'd14, 1'b1, 4'd14, 32'h5555_AAAA, 1'b0, '0);
        drive(5'h13, 4'd14, 4'd13, 1'b0, '0, '0, 1'b0, '0);
        // R8: reset after use
        rst_n = 1'b0;
        drive(5'h11, 4'd8, 4'd14, 1'b0, '0, '0, 1'b0, '0);
        rst_n = 1'b1;
        foreach (modes[i]) sweep_read(modes[i]);
        // Mixed traffic
        for (int n = 0; n < 4000; n++) begin
            rst_n = ($urandom_range(0, 299) != 0);
            drive(modes[$urandom_range(0, 8)], 4'($urandom), 4'($urandom),
                  1'($urandom), 4'($urandom), $urandom, 1'($urandom), $urandom);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule